// File: doc/BRIEF.md
# Dual-Function PWM and Digital Comparator Unit

This block is an 8-bit unit that either produces a pair of complementary pulse-width modulated phases with a dead gap between them, or compares two 8-bit operands and reports the result. A function-select input chooses between the two. Each operand comes from its own four-way source selector whose inputs are ports on the block, so the operand producers stay outside it. In pulse mode the positive operand is the duty value and an 8-bit free-running counter sets the period of 256 clocks.

One mode input sets both the end of the duty range that the pulse output can reach and whether the comparator uses a strict or a non-strict test. The dead gap is a whole number of block clocks: 1, 2, 4 or 8, picked by a 2-bit code. With a 100 MHz clock this gives 10 to 80 ns. A power-down input has two behaviours. In one, it clears the unit at once and drives both outputs low. In the other, it freezes the unit and holds the outputs where they are, and when it is released the unit waits two clocks before it runs again. An enable input and a clock-inversion input complete the controls.

Top module: `pwm_dcmp_unit`

## Requirements
- R1: While `rstN` is low, `outP` and `outN` are 0, and the counter, phase, gap timer and comparator result are cleared.
- R2: With `cfgFuncSel`=1 (comparator), `outP` is 0 and `outN` carries the registered comparator result. With `cfgFuncSel`=0 (pulse), `outN` carries the complementary phase.
- R3: In pulse mode with `cfgMode`=0, the raw phase is high while counter < duty. The counter counts 0 to 255 and wraps. Duty 0 gives no high time, and duty 255 leaves one low clock per period.
- R4: In pulse mode with `cfgMode`=1, the raw phase is high while counter <= duty. Duty 255 keeps `outP` high for the whole period, and duty 0 gives one high clock.
- R5: In comparator mode the result is A > B when `cfgMode`=0 and A >= B when `cfgMode`=1. It is registered, so `outN` shows new operands after the next active clock edge and not before.
- R6: After the raw phase changes, both outputs are 0 for exactly 2^`cfgDeadCode` clocks, and then the output for the new phase rises. `outP` and `outN` are never both 1.
- R7: Operand A is `posSrc[cfgPosSel]` and operand B is `negSrc[cfgNegSel]`, with the two selects independent of each other.
- R8: With `cfgEnable`=0, every active edge clears the unit, so both outputs are 0 from the first edge onward.
- R9: With `cfgPdSync`=0, `pwrDown`=1 clears the unit asynchronously, without waiting for a clock. Both outputs go to 0 at once, and the unit restarts from count 0 when `pwrDown` is released.
- R10: With `cfgPdSync`=1, `pwrDown`=1 freezes all state at the next edge and holds both outputs. After release, the first two active edges are skipped and the third one updates the unit.
- R11: With `cfgClkInv`=1, the unit updates on the falling edge of `clk` instead of the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (10 ns dead-gap unit at 100 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFuncSel | input | 1 | 0 = pulse generator, 1 = comparator |
| cfgEnable | input | 1 | 1 = unit runs, 0 = unit cleared |
| cfgClkInv | input | 1 | 1 = use the falling edge of clk |
| cfgMode | input | 1 | 0 = strict compare / duty down to 0%, 1 = non-strict / duty up to 100% |
| cfgDeadCode | input | 2 | Dead gap of 2^code clocks |
| cfgPosSel | input | 2 | Operand A source index |
| cfgNegSel | input | 2 | Operand B source index |
| posSrc | input | 4x8 | Candidate sources for operand A (duty) |
| negSrc | input | 4x8 | Candidate sources for operand B |
| pwrDown | input | 1 | Power-down request |
| cfgPdSync | input | 1 | 0 = asynchronous clear, 1 = clock-synchronous hold |
| outP | output | 1 | Positive pulse phase |
| outN | output | 1 | Negative pulse phase or comparator result |

## Verification
The registered results (counter, phase, gap timer and comparator flag) change one active edge after the inputs that feed them. The bench drives inputs on the falling edge, updates its reference model on the rising edge, and compares 2 ns after the rising edge. The outputs follow `cfgFuncSel` and `cfgDeadCode` without a clock, and they follow an asynchronous power-down within the same cycle, so those checks sample 1 ns after the stimulus. The wake delay is checked by three samples taken after consecutive edges, expecting old, old, then new. The clock-inversion check samples between the falling edge and the next rising edge, where only a falling-edge design can already show the new value.

// File: rtl/pwm_dcmp_pkg.sv
package pwm_dcmp_pkg;
  localparam int DATA_W   = 8;
  localparam int SRC_N    = 4;
  localparam int SEL_W    = $clog2(SRC_N);
  localparam int CODE_W   = 2;
  localparam int MAX_GAP  = 1 << ((1 << CODE_W) - 1);
  localparam int GAP_W    = $clog2(MAX_GAP + 1);
  localparam int WAKE_CYC = 2;
  localparam int WAKE_W   = $clog2(WAKE_CYC + 1);

  typedef struct packed {
    logic run;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/pwm_dcmp_ctrl.sv
module pwm_dcmp_ctrl
  import pwm_dcmp_pkg::*;
(
  input  logic    clk,
  input  logic    arstN,
  input  logic    cfgEnable,
  input  logic    cfgPdSync,
  input  logic    pwrDown,
  output strobe_t strobe
);
  logic [WAKE_W-1:0] wakeCnt;
  logic holdReq;

  assign holdReq = cfgPdSync & pwrDown;

  // wake timer: reloaded while held, counts down after release
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      wakeCnt <= '0;
    end else if (holdReq) begin
      wakeCnt <= WAKE_W'(WAKE_CYC);
    end else if (wakeCnt != '0) begin
      wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign strobe.clear = ~cfgEnable;
  assign strobe.run   = cfgEnable & ~holdReq & (wakeCnt == '0);
endmodule

// File: rtl/pwm_dcmp_datapath.sv
module pwm_dcmp_datapath
  import pwm_dcmp_pkg::*;
(
  input  logic                        clk,
  input  logic                        arstN,
  input  strobe_t                     strobe,
  input  logic                        cfgFuncSel,
  input  logic                        cfgMode,
  input  logic [CODE_W-1:0]           cfgDeadCode,
  input  logic [SEL_W-1:0]            cfgPosSel,
  input  logic [SEL_W-1:0]            cfgNegSel,
  input  logic [SRC_N-1:0][DATA_W-1:0] posSrc,
  input  logic [SRC_N-1:0][DATA_W-1:0] negSrc,
  output logic                        outP,
  output logic                        outN
);
  logic [DATA_W-1:0] opA, opB, cnt;
  logic [GAP_W-1:0]  gapLen, runLen;
  logic rawPhase, phaseQ, matchQ, matchNext, settled;

  assign opA = posSrc[cfgPosSel];
  assign opB = negSrc[cfgNegSel];

  // one mode bit sets both the duty end point and the compare strictness
  generate
    if (DATA_W > 0) begin : g_cmp
      assign rawPhase  = cfgMode ? (cnt <= opA) : (cnt < opA);
      assign matchNext = cfgMode ? (opA >= opB) : (opA > opB);
    end
  endgenerate

  assign gapLen = GAP_W'(1) << cfgDeadCode;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
      runLen <= '0;
      matchQ <= 1'b0;
    end else if (strobe.clear) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
      runLen <= '0;
      matchQ <= 1'b0;
    end else if (strobe.run) begin
      cnt    <= cnt + 1'b1;
      matchQ <= matchNext;
      if (rawPhase != phaseQ) begin
        phaseQ <= rawPhase;
        runLen <= '0;
      end else if (runLen != GAP_W'(MAX_GAP)) begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  assign settled = (runLen >= gapLen);
  assign outP = ~cfgFuncSel & phaseQ & settled;
  assign outN = cfgFuncSel ? matchQ : (~phaseQ & settled);
endmodule

// File: rtl/pwm_dcmp_unit.sv
module pwm_dcmp_unit
  import pwm_dcmp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgFuncSel,
  input  logic                         cfgEnable,
  input  logic                         cfgClkInv,
  input  logic                         cfgMode,
  input  logic [CODE_W-1:0]            cfgDeadCode,
  input  logic [SEL_W-1:0]             cfgPosSel,
  input  logic [SEL_W-1:0]             cfgNegSel,
  input  logic [SRC_N-1:0][DATA_W-1:0] posSrc,
  input  logic [SRC_N-1:0][DATA_W-1:0] negSrc,
  input  logic                         pwrDown,
  input  logic                         cfgPdSync,
  output logic                         outP,
  output logic                         outN
);
  logic clkInt, arstN;
  strobe_t strobe;

  assign clkInt = clk ^ cfgClkInv;
  assign arstN  = rstN & ~(pwrDown & ~cfgPdSync);

  pwm_dcmp_ctrl u_ctrl (
    .clk(clkInt), .arstN(arstN), .cfgEnable(cfgEnable),
    .cfgPdSync(cfgPdSync), .pwrDown(pwrDown), .strobe(strobe)
  );

  pwm_dcmp_datapath u_dp (
    .clk(clkInt), .arstN(arstN), .strobe(strobe),
    .cfgFuncSel(cfgFuncSel), .cfgMode(cfgMode), .cfgDeadCode(cfgDeadCode),
    .cfgPosSel(cfgPosSel), .cfgNegSel(cfgNegSel),
    .posSrc(posSrc), .negSrc(negSrc), .outP(outP), .outN(outN)
  );
endmodule

// File: rtl/pwm_dcmp_unit_chk.sv
module pwm_dcmp_unit_chk
  import pwm_dcmp_pkg::*;
(
  input logic              clkInt,
  input logic              rstN,
  input logic              arstN,
  input logic              cfgFuncSel,
  input logic              cfgEnable,
  input logic              cfgPdSync,
  input logic [CODE_W-1:0] cfgDeadCode,
  input logic              pwrDown,
  input logic              outP,
  input logic              outN
);
  AST_PHASES_EXCLUSIVE: assert property (@(posedge clkInt) disable iff (!arstN)
    !cfgFuncSel |-> !(outP && outN)); // R6

  AST_ASYNC_PD_ZERO: assert property (@(posedge clkInt) disable iff (!rstN)
    (pwrDown && !cfgPdSync) |-> (!outP && !outN)); // R9

  AST_SYNC_PD_HOLD: assert property (@(posedge clkInt) disable iff (!arstN)
    (cfgPdSync && pwrDown && $past(cfgPdSync && pwrDown) && cfgEnable && $past(cfgEnable)
     && $stable(cfgFuncSel) && $stable(cfgDeadCode))
    |-> ($stable(outP) && $stable(outN))); // R10

  AST_DISABLED_QUIET: assert property (@(posedge clkInt) disable iff (!arstN)
    (!cfgEnable && $past(!cfgEnable)) |-> (!outP && !outN)); // R8
endmodule

bind pwm_dcmp_unit pwm_dcmp_unit_chk u_chk (
  .clkInt(clkInt), .rstN(rstN), .arstN(arstN), .cfgFuncSel(cfgFuncSel),
  .cfgEnable(cfgEnable), .cfgPdSync(cfgPdSync), .cfgDeadCode(cfgDeadCode),
  .pwrDown(pwrDown), .outP(outP), .outN(outN)
);

// File: tb/pwm_dcmp_unit_test.sv
module pwm_dcmp_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgFuncSel = 1'b0, cfgEnable = 1'b1, cfgClkInv = 1'b0, cfgMode = 1'b0;
  logic [1:0] cfgDeadCode = 2'd0, cfgPosSel = 2'd0, cfgNegSel = 2'd0;
  logic [3:0][7:0] posSrc = '0, negSrc = '0;
  logic pwrDown = 1'b0, cfgPdSync = 1'b0;
  logic outP, outN;

  int total = 0, bad = 0;
  bit modelOn = 1'b1;
  bit finished = 1'b0;
  int mCnt, mPhase, mRun, mMatch, mWake;

  always #4 clk = ~clk;

  pwm_dcmp_unit uut (
    .clk(clk), .rstN(rstN), .cfgFuncSel(cfgFuncSel), .cfgEnable(cfgEnable),
    .cfgClkInv(cfgClkInv), .cfgMode(cfgMode), .cfgDeadCode(cfgDeadCode),
    .cfgPosSel(cfgPosSel), .cfgNegSel(cfgNegSel), .posSrc(posSrc), .negSrc(negSrc),
    .pwrDown(pwrDown), .cfgPdSync(cfgPdSync), .outP(outP), .outN(outN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    if (modelOn) begin
      int a, b, gap, expP, expN;
      bit go, raw;
      a = int'(posSrc[cfgPosSel]);
      b = int'(negSrc[cfgNegSel]);
      if (!rstN || (pwrDown && !cfgPdSync)) begin
        mCnt = 0; mPhase = 0; mRun = 0; mMatch = 0; mWake = 0;
      end else begin
        go = cfgEnable && !(cfgPdSync && pwrDown) && (mWake == 0);
        if (cfgPdSync && pwrDown) mWake = 2;
        else if (mWake > 0) mWake--;
        if (!cfgEnable) begin
          mCnt = 0; mPhase = 0; mRun = 0; mMatch = 0;
        end else if (go) begin
          raw = cfgMode ? (mCnt <= a) : (mCnt < a);
          mMatch = cfgMode ? int'(a >= b) : int'(a > b);
          if (int'(raw) != mPhase) begin mPhase = int'(raw); mRun = 0; end
          else if (mRun < 8) mRun++;
          mCnt = (mCnt + 1) % 256;
        end
      end
      #2;
      gap = 1 << cfgDeadCode;
      expP = (!cfgFuncSel && mPhase == 1 && mRun >= gap) ? 1 : 0;
      expN = cfgFuncSel ? mMatch : ((mPhase == 0 && mRun >= gap) ? 1 : 0);
      if (modelOn) begin
        check(outP == expP[0], cfgFuncSel ? "R2 outP" : "R3 outP", outP, expP);
        check(outN == expN[0], cfgFuncSel ? "R5 outN" : "R6 outN", outN, expN);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countHigh(output int n);
    n = 0;
    repeat (256) begin
      @(posedge clk); #2;
      if (outP) n++;
    end
  endtask

  task automatic pulseCase(input bit md, input int duty, input int code, input int exp, input string req);
    int n;
    @(negedge clk);
    cfgMode = md; cfgDeadCode = 2'(code); posSrc[2] = 8'(duty);
    tick(300);
    countHigh(n);
    check(n == exp, req, n, exp);
  endtask

  task automatic measureGap(input bit fromP, output int g);
    g = 0;
    repeat (600) begin
      @(posedge clk); #2;
      if (fromP ? outP : outN) break;
    end
    repeat (600) begin
      @(posedge clk); #2;
      if (!(fromP ? outP : outN)) break;
    end
    repeat (20) begin
      if (fromP ? outN : outP) break;
      g++;
      @(posedge clk); #2;
    end
  endtask

  task automatic cmpCase(input int ps, input int ns, input bit exp, input string req);
    @(negedge clk);
    cfgPosSel = 2'(ps); cfgNegSel = 2'(ns);
    @(posedge clk); #2;
    check(outN == exp, req, outN, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    bit held;
    tick(3);
    check(outP == 1'b0 && outN == 1'b0, "R1 reset outputs", {outP, outN}, 0);
    rstN = 1'b1;
    cfgPosSel = 2'd2;

    // pulse sweep (R3, R4), period counts include the dead gap
    pulseCase(0, 0, 0, 0, "R3 duty0 mode0");
    pulseCase(0, 1, 0, 0, "R3 duty1 mode0");
    pulseCase(0, 128, 0, 127, "R3 duty128 mode0");
    pulseCase(0, 255, 0, 254, "R3 duty255 mode0");
    pulseCase(1, 0, 0, 0, "R4 duty0 mode1");
    pulseCase(1, 1, 0, 1, "R4 duty1 mode1");
    pulseCase(1, 128, 0, 128, "R4 duty128 mode1");
    pulseCase(1, 255, 0, 256, "R4 duty255 mode1");
    pulseCase(0, 128, 3, 120, "R6 duty128 code3");

    // dead gap lengths (R6)
    pulseCase(0, 128, 2, 124, "R6 duty128 code2");
    measureGap(1'b1, g);
    check(g == 4, "R6 gap code2 P->N", g, 4);
    @(negedge clk); cfgDeadCode = 2'd3;
    measureGap(1'b0, g);
    check(g == 8, "R6 gap code3 N->P", g, 8);
    @(negedge clk); cfgDeadCode = 2'd1;
    measureGap(1'b1, g);
    check(g == 2, "R6 gap code1 P->N", g, 2);

    // comparator (R2, R5, R7)
    @(negedge clk);
    cfgFuncSel = 1'b1; cfgMode = 1'b0;
    posSrc = {8'd70, 8'd60, 8'd50, 8'd40};
    negSrc = {8'd75, 8'd65, 8'd55, 8'd45};
    #1 check(outP == 1'b0, "R2 outP low in comparator", outP, 0);
    cmpCase(2, 1, 1'b1, "R7 sel 2 vs 1");
    cmpCase(0, 3, 1'b0, "R7 sel 0 vs 3");
    cmpCase(3, 2, 1'b1, "R7 sel 3 vs 2");
    cmpCase(1, 0, 1'b1, "R7 sel 1 vs 0");
    @(negedge clk);
    posSrc[0] = 8'd99; negSrc[0] = 8'd99; cfgPosSel = 2'd0; cfgNegSel = 2'd0;
    @(posedge clk); #2;
    check(outN == 1'b0, "R5 equal strict", outN, 0);
    @(negedge clk); cfgMode = 1'b1;
    #1 check(outN == 1'b0, "R5 registered, not yet", outN, 0);
    @(posedge clk); #2;
    check(outN == 1'b1, "R5 equal non-strict", outN, 1);
    @(negedge clk); negSrc[0] = 8'd100;
    @(posedge clk); #2;
    check(outN == 1'b0, "R5 A<B non-strict", outN, 0);

    // enable (R8)
    @(negedge clk); negSrc[0] = 8'd1; cfgEnable = 1'b0;
    @(posedge clk); #2;
    check(outN == 1'b0, "R8 disabled clears", outN, 0);
    @(negedge clk); cfgFuncSel = 1'b0; cfgMode = 1'b1; posSrc[0] = 8'd255;
    tick(5);
    check(outP == 1'b0 && outN == 1'b0, "R8 disabled pulse quiet", {outP, outN}, 0);
    @(negedge clk); cfgEnable = 1'b1; cfgMode = 1'b0; posSrc[0] = 8'd128; cfgDeadCode = 2'd0;
    tick(40);

    // asynchronous power-down (R9)
    @(negedge clk); cfgPdSync = 1'b0; pwrDown = 1'b1;
    #1 check(outP == 1'b0 && outN == 1'b0, "R9 async forced low", {outP, outN}, 0);
    tick(6);
    @(negedge clk); pwrDown = 1'b0;
    tick(3);
    check(outP == 1'b1, "R9 restart from count 0", outP, 1);

    // synchronous power-down hold and wake delay (R10)
    tick(10);
    @(negedge clk); cfgPdSync = 1'b1; pwrDown = 1'b1;
    @(posedge clk); #2;
    held = outP;
    tick(30);
    check(outP == held, "R10 outputs held", outP, held);
    @(negedge clk); pwrDown = 1'b0;
    tick(20);
    @(negedge clk);
    cfgFuncSel = 1'b1; cfgMode = 1'b0; posSrc[0] = 8'd10; negSrc[0] = 8'd20;
    tick(2);
    check(outN == 1'b0, "R10 setup", outN, 0);
    pwrDown = 1'b1;
    tick(2);
    posSrc[0] = 8'd30;
    tick(3);
    check(outN == 1'b0, "R10 frozen while down", outN, 0);
    pwrDown = 1'b0;
    @(posedge clk); #2;
    check(outN == 1'b0, "R10 wake edge 1 skipped", outN, 0);
    @(posedge clk); #2;
    check(outN == 1'b0, "R10 wake edge 2 skipped", outN, 0);
    @(posedge clk); #2;
    check(outN == 1'b1, "R10 wake edge 3 runs", outN, 1);

    // clock inversion (R11)
    modelOn = 1'b0;
    @(negedge clk); posSrc[0] = 8'd0; negSrc[0] = 8'd0; cfgClkInv = 1'b1;
    tick(4);
    check(outN == 1'b0, "R11 setup", outN, 0);
    @(posedge clk); #1;
    posSrc[0] = 8'd9;
    #2;
    check(outN == 1'b0, "R11 no rising-edge update", outN, 0);
    #3;
    check(outN == 1'b1, "R11 falling-edge update", outN, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule